// File: doc/BRIEF.md
# ECC-Protected RAM Controller with Hardware Initialization

This block wraps a single-port on-chip RAM whose words are protected by a single-error-correct, double-error-detect Hamming code. A 32-bit word is stored as a 39-bit codeword: six Hamming check bits and one overall parity bit. A data port lets clients read and write words. A small 32-bit register port lets software enable checking and start a sweep that clears the whole array. The same port gives access to the error pending flags, the interrupt enable and a set/clear interrupt mask.

Software starts the clearing sweep before it turns checking on. The engine writes one all-zero codeword per cycle, which is a valid codeword, until every address has been visited. It then raises a completion flag that software polls. After that, reads are corrected on the fly. Each single-bit error raises a correctable pending flag, and each uncorrectable pattern raises a separate flag. These flags drive two interrupt lines.

Top module: `ecc_ram_ctl`

## Requirements
- R1: After reset, every register reads 0, both interrupt outputs are low and `mem_busy` is low.
- R2: Offset 0x08 holds an enable field in bits [1:0], which is read/write. Correction and error flagging are active only when both bits are 1. Every other bit of 0x08 reads 0.
- R3: Writing 1 to bit 16 of offset 0x08 starts the sweep. Starting the sweep clears bit 0 of offset 0x0C, then holds `mem_busy` high for exactly 2^ADDR_W cycles while zero is written to every word. Bit 0 of 0x0C then reads 1. A second start while the sweep runs is ignored. Bit 8 of 0x0C always reads 0.
- R4: While `mem_busy` is high, data-port requests are ignored: nothing is written and no read response is produced.
- R5: A data-port read returns `mem_rvalid` with data exactly one cycle after the request. A word written with correction enabled reads back unchanged and without error flags.
- R6: While correction is off, writes store the data with all seven check bits zero, and reads return the stored data bits unmodified and set no flags.
- R7: With correction on, a read of a codeword with a single flipped bit returns corrected data and sets bit 0 of offset 0x20. For example, a word holding exactly one set bit that was stored with correction off reads back as 0.
- R8: With correction on, a read of a codeword with two flipped bits returns the uncorrected data bits and sets bit 8 of offset 0x20. For example, a word holding exactly two set bits that was stored with correction off reads back unchanged.
- R9: The pending bits at offset 0x20 clear when 1 is written to them. Writing 0 leaves them unchanged.
- R10: Bit 0 of offset 0x10 is the correctable-error interrupt enable. `irq_serr` is high exactly when bit 0 of 0x20 is set, the enable is set and the source is unmasked.
- R11: Writing 1 to bit 0 or bit 8 of offset 0x28 masks the correctable or the uncorrectable source. Writing 1 to the same bit of offset 0x2C unmasks it. Both offsets read back the mask. `irq_derr` is high exactly when bit 8 of 0x20 is set and that source is unmasked.
- R12: Offsets not listed above read 0 and ignore writes. Writes to offset 0x0C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | input | 1 | Data-port request |
| mem_we | input | 1 | Data-port write (1) or read (0) |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | 32 | Write data |
| mem_rdata | output | 32 | Read data, valid with `mem_rvalid` |
| mem_rvalid | output | 1 | Read response strobe |
| mem_busy | output | 1 | Sweep running; requests ignored |
| irq_serr | output | 1 | Correctable-error interrupt |
| irq_derr | output | 1 | Uncorrectable-error interrupt |

## Verification
The bench builds the block with ADDR_W = 4, which gives a 16-word array. At that depth the whole sweep can be timed cycle by cycle, and a restart can be injected in the middle of it, along with an ignored write and an ignored read. The sweep also reaches the top address, so the bench can show that words written before the sweep read back as clean zeros. Correction is switched off to store words with stale check bits. Turning it back on then produces the correctable and uncorrectable patterns without a fault-injection input.

// File: rtl/ecc_ram_ctl.sv
module ecc_ram_ctl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_wdata,
  output logic [31:0]       mem_rdata,
  output logic              mem_rvalid,
  output logic              mem_busy,
  output logic              irq_serr,
  output logic              irq_derr
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = 32;
  localparam int PW    = 6;
  localparam int CW    = DW + PW + 1;

  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_INIT = 8'h0C;
  localparam logic [7:0] OFS_IEN  = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam logic [7:0] OFS_MSET = 8'h28;
  localparam logic [7:0] OFS_MCLR = 8'h2C;

  function automatic logic [CW-1:0] place(input logic [DW-1:0] d);
    logic [CW-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    return cw;
  endfunction

  function automatic logic [DW-1:0] extract(input logic [CW-1:0] cw);
    logic [DW-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        d[k] = cw[p];
        k++;
      end
    return d;
  endfunction

  function automatic logic [PW-1:0] syndrome(input logic [CW-1:0] cw);
    logic [PW-1:0] s;
    s = '0;
    for (int i = 0; i < PW; i++)
      for (int p = 1; p < CW; p++)
        if (p[i]) s[i] = s[i] ^ cw[p];
    return s;
  endfunction

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] cw;
    logic [PW-1:0] s;
    cw = place(d);
    s  = syndrome(cw);
    for (int i = 0; i < PW; i++) cw[1 << i] = s[i];
    cw[0] = ^cw[CW-1:1];
    return cw;
  endfunction

  logic [1:0]        ctrl;
  logic              ser_en, pend_s, pend_d, mask_s, mask_d;
  logic              init_done, busy;
  logic [ADDR_W-1:0] icnt;
  logic [CW-1:0]     arr [DEPTH];
  logic [CW-1:0]     rd_word;
  logic              rvalid_q;

  wire ecc_on  = &ctrl;
  wire wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  wire wr_ien  = reg_we && (reg_addr == OFS_IEN);
  wire wr_stat = reg_we && (reg_addr == OFS_STAT);
  wire wr_mset = reg_we && (reg_addr == OFS_MSET);
  wire wr_mclr = reg_we && (reg_addr == OFS_MCLR);
  wire start   = wr_ctrl && reg_wdata[16] && !busy;
  wire acc     = mem_req && !busy;
  wire unused_wbits = ^{reg_wdata[31:17], reg_wdata[15:9], reg_wdata[7:2]};

  logic [PW-1:0] syn;
  logic          par, serr, derr;
  logic [CW-1:0] fixed;

  always_comb begin
    syn   = syndrome(rd_word);
    par   = ^rd_word;
    fixed = rd_word;
    if (par && syn != '0 && int'(syn) < CW) fixed[syn] = ~fixed[syn];
    serr  = ecc_on && par && int'(syn) < CW;
    derr  = ecc_on && ((!par && syn != '0) || (par && int'(syn) >= CW));
  end

  assign mem_rdata  = ecc_on ? extract(fixed) : extract(rd_word);
  assign mem_rvalid = rvalid_q;
  assign mem_busy   = busy;
  assign irq_serr   = pend_s && ser_en && !mask_s;
  assign irq_derr   = pend_d && !mask_d;

  always_ff @(posedge clk) begin
    if (busy)
      arr[icnt] <= '0;
    else if (acc && mem_we)
      arr[mem_addr] <= ecc_on ? encode(mem_wdata) : place(mem_wdata);
    if (acc && !mem_we) rd_word <= arr[mem_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      ser_en    <= 1'b0;
      pend_s    <= 1'b0;
      pend_d    <= 1'b0;
      mask_s    <= 1'b0;
      mask_d    <= 1'b0;
      init_done <= 1'b0;
      busy      <= 1'b0;
      icnt      <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= acc && !mem_we;
      if (wr_ctrl) ctrl <= reg_wdata[1:0];
      if (wr_ien) ser_en <= reg_wdata[0];
      if (start) begin
        busy      <= 1'b1;
        init_done <= 1'b0;
        icnt      <= '0;
      end else if (busy) begin
        if (icnt == ADDR_W'(DEPTH - 1)) begin
          busy      <= 1'b0;
          init_done <= 1'b1;
        end else begin
          icnt <= icnt + 1'b1;
        end
      end
      if (rvalid_q && serr) pend_s <= 1'b1;
      else if (wr_stat && reg_wdata[0]) pend_s <= 1'b0;
      if (rvalid_q && derr) pend_d <= 1'b1;
      else if (wr_stat && reg_wdata[8]) pend_d <= 1'b0;
      if (wr_mset) begin
        mask_s <= mask_s | reg_wdata[0];
        mask_d <= mask_d | reg_wdata[8];
      end
      if (wr_mclr) begin
        mask_s <= mask_s & ~reg_wdata[0];
        mask_d <= mask_d & ~reg_wdata[8];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata[1:0] = ctrl;
      OFS_INIT: reg_rdata[0]   = init_done;
      OFS_IEN:  reg_rdata[0]   = ser_en;
      OFS_STAT: begin reg_rdata[0] = pend_s; reg_rdata[8] = pend_d; end
      OFS_MSET,
      OFS_MCLR: begin reg_rdata[0] = mask_s; reg_rdata[8] = mask_d; end
      default:  reg_rdata = '0;
    endcase
  end

endmodule

module ecc_ram_ctl_chk #(
  parameter int DEPTH = 64
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic init_done,
  input logic mem_req,
  input logic mem_we,
  input logic mem_rvalid,
  input logic ecc_on,
  input logic pend_s,
  input logic pend_d,
  input logic ser_en,
  input logic irq_serr,
  input logic irq_derr
);

  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  a_r3_sweep_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= DEPTH);

  a_r3_done_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(busy));

  a_r3_done_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !init_done);

  a_r4_no_response_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !mem_rvalid);

  a_r5_response_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> $past(mem_req && !mem_we));

  a_r7_single_needs_ecc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_s) |-> $past(ecc_on && mem_rvalid));

  a_r8_double_needs_ecc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_d) |-> $past(ecc_on && mem_rvalid));

  a_r10_serr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_serr |-> (pend_s && ser_en));

  a_r11_derr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_derr |-> pend_d);

endmodule

bind ecc_ram_ctl ecc_ram_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .init_done(init_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_rvalid(mem_rvalid),
  .ecc_on(ecc_on), .pend_s(pend_s), .pend_d(pend_d), .ser_en(ser_en),
  .irq_serr(irq_serr), .irq_derr(irq_derr)
);

// File: tb/test_ecc_ram_ctl.sv
module test_ecc_ram_ctl;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req = 1'b0;
  logic          mem_we = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [31:0]   mem_wdata = '0;
  logic [31:0]   mem_rdata;
  logic          mem_rvalid, mem_busy, irq_serr, irq_derr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  ecc_ram_ctl #(.ADDR_W(AW)) i_ecc_ram_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .mem_busy(mem_busy),
    .irq_serr(irq_serr), .irq_derr(irq_derr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic mem_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_req = 1'b0; mem_we = 1'b0;
  endtask

  task automatic mem_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    mem_req = 1'b1; mem_we = 1'b0; mem_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    mem_req = 1'b0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R4 unexpected read response: actual %h expected none", mem_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, mem_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(8'h08, 32'h0, "R1 ctrl");
    rd_reg(8'h0C, 32'h0, "R1 init status");
    rd_reg(8'h10, 32'h0, "R1 irq enable");
    rd_reg(8'h20, 32'h0, "R1 pending");
    rd_reg(8'h28, 32'h0, "R1 mask");
    chk("R1 irq lines/busy", {29'b0, irq_serr, irq_derr, mem_busy}, 32'h0);

    // R2 enable field, other bits read 0
    wr_reg(8'h08, 32'hFFFE_FFFF);
    rd_reg(8'h08, 32'h3, "R2 ctrl field");
    wr_reg(8'h08, 32'h1);
    rd_reg(8'h08, 32'h1, "R2 ctrl partial");

    // words written before sweep, including top address
    mem_wr(4'd3, 32'h0000_FFFF);
    mem_wr(4'd15, 32'h0000_0005);

    // R3 sweep timing, R4 ignored accesses, restart ignored
    @(negedge clk);
    reg_addr = 8'h08; reg_we = 1'b1; reg_wdata = 32'h0001_0000;
    @(negedge clk);
    reg_we = 1'b0;
    n = 0;
    while (mem_busy && n < 100) begin
      n++;
      if (n == 1) begin reg_addr = 8'h0C; #1 chk("R3 done cleared during sweep", reg_rdata, 32'h0); end
      if (n == 2) begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = 4'd5; mem_wdata = 32'h0000_ABCD; end
      if (n == 3) begin mem_we = 1'b0; end
      if (n == 4) begin mem_req = 1'b0; reg_addr = 8'h08; reg_we = 1'b1; reg_wdata = 32'h0001_0000; end
      if (n == 5) reg_we = 1'b0;
      @(negedge clk);
    end
    chk("R3 sweep length", n, DEPTH);
    rd_reg(8'h0C, 32'h1, "R3 done set, second port flag 0");

    // R12 writes to status offset ignored
    wr_reg(8'h0C, 32'h0);
    rd_reg(8'h0C, 32'h1, "R12 init status write ignored");

    // R3/R4 swept words read clean zero with checking on
    wr_reg(8'h08, 32'h3);
    mem_rd(4'd3, 32'h0, "R3 swept word 3");
    mem_rd(4'd15, 32'h0, "R3 swept top word");
    mem_rd(4'd5, 32'h0, "R4 write during sweep ignored");
    rd_reg(8'h20, 32'h0, "R3 swept words clean");

    // R5 round trip with checking on
    mem_wr(4'd2, 32'hDEAD_BEEF);
    mem_wr(4'd15, 32'h1234_5678);
    mem_rd(4'd2, 32'hDEAD_BEEF, "R5 readback word 2");
    mem_rd(4'd15, 32'h1234_5678, "R5 readback word 15");
    rd_reg(8'h20, 32'h0, "R5 no flags");

    // R6 checking off: raw store and read
    wr_reg(8'h08, 32'h0);
    mem_wr(4'd7, 32'h0000_0010);
    mem_wr(4'd8, 32'h0000_0003);
    mem_rd(4'd7, 32'h0000_0010, "R6 raw read word 7");
    wr_reg(8'h08, 32'h1);
    mem_rd(4'd8, 32'h0000_0003, "R2 one enable bit leaves checking off");
    rd_reg(8'h20, 32'h0, "R6 no flags while off");

    // R7 single error corrected
    wr_reg(8'h08, 32'h3);
    mem_rd(4'd7, 32'h0, "R7 corrected data");
    rd_reg(8'h20, 32'h1, "R7 single pending");
    chk("R10 serr low without enable", {31'b0, irq_serr}, 32'h0);
    chk("R11 derr low", {31'b0, irq_derr}, 32'h0);

    // R10 enable and R11 mask on single source
    wr_reg(8'h10, 32'h1);
    #1 chk("R10 serr asserted", {31'b0, irq_serr}, 32'h1);
    wr_reg(8'h28, 32'h1);
    rd_reg(8'h28, 32'h1, "R11 mask set readback");
    chk("R11 serr masked", {31'b0, irq_serr}, 32'h0);
    wr_reg(8'h2C, 32'h1);
    rd_reg(8'h2C, 32'h0, "R11 mask clear readback");
    chk("R11 serr unmasked", {31'b0, irq_serr}, 32'h1);

    // R9 write-one-to-clear
    wr_reg(8'h20, 32'h0);
    rd_reg(8'h20, 32'h1, "R9 zero write keeps pending");
    wr_reg(8'h20, 32'h1);
    rd_reg(8'h20, 32'h0, "R9 one write clears");
    chk("R10 serr drops after clear", {31'b0, irq_serr}, 32'h0);

    // R8 double error
    mem_rd(4'd8, 32'h0000_0003, "R8 uncorrected data");
    rd_reg(8'h20, 32'h100, "R8 double pending");
    chk("R11 derr asserted", {31'b0, irq_derr}, 32'h1);
    wr_reg(8'h28, 32'h100);
    rd_reg(8'h28, 32'h100, "R11 double mask readback");
    chk("R11 derr masked", {31'b0, irq_derr}, 32'h0);
    wr_reg(8'h2C, 32'h100);
    #1 chk("R11 derr unmasked", {31'b0, irq_derr}, 32'h1);
    wr_reg(8'h20, 32'h100);
    rd_reg(8'h20, 32'h0, "R9 double cleared");

    // R12 undefined offsets
    wr_reg(8'h04, 32'hFFFF_FFFF);
    wr_reg(8'h30, 32'hFFFF_FFFF);
    rd_reg(8'h04, 32'h0, "R12 undefined reads 0");
    rd_reg(8'h30, 32'h0, "R12 undefined reads 0 high");
    rd_reg(8'h08, 32'h3, "R12 ctrl unchanged");
    rd_reg(8'h10, 32'h1, "R12 enable unchanged");
    rd_reg(8'h28, 32'h0, "R12 mask unchanged");

    repeat (3) @(negedge clk);
    chk("R5 all responses seen", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule